// File: doc/BRIEF.md
# Four-Operation Arithmetic Calculator Unit

This block is a purely combinational arithmetic datapath. It takes two operands of a parameterized width N, a two-bit operation code and a signedness control. It returns a double-width result together with three status flags: overflow, zero divisor and result-valid. The four operations are sum, difference, product and quotient. Each can run in two's-complement mode or in plain-magnitude mode.

The block has no clock and no handshake, so the stream conventions do not apply to it. The flags respond in the same delta cycle as the result. Products keep all 2N bits. The other three operations produce an N-bit value, which is placed in the low half of the result and extended into the upper half to suit the selected mode. A zero divisor never produces an undefined result. It is reported through its own flag and yields a known zero.

Top module: `calc_unit`

## Requirements
- R1: The operation code selects the function as follows: 2'b00 sum, 2'b01 difference (a minus b), 2'b10 product, 2'b11 quotient (a divided by b).
- R2: In unsigned mode, sum and difference wrap to their low N bits. The overflow flag is set on a carry out of the sum, and on a borrow in the difference (a < b). Example at N=8: 250 + 20 gives 14 with overflow set.
- R3: In signed mode, a sum overflows exactly when both operands share a sign and the N-bit result carries the other sign.
- R4: In signed mode, a difference overflows exactly when the operands differ in sign and the result's sign differs from a's sign. An in-range negative difference, such as 5 - 10, is returned as a negative value.
- R5: A product returns all 2N bits of the exact signed or unsigned product and never sets overflow.
- R6: A quotient with a nonzero divisor is the unsigned integer quotient in unsigned mode. In signed mode it is truncated toward zero.
- R7: In signed mode, the most negative value divided by -1 sets overflow and returns the most negative value.
- R8: With a zero divisor in a quotient, the zero-divisor flag is 1, valid is 0, overflow is 0 and the result is all zeros. In every other case, valid is 1 and the zero-divisor flag is 0.
- R9: For sum, difference and quotient, bits [2N-1:N] of the result copy bit N-1 in signed mode and are zero in unsigned mode.
- R10: The behaviour above holds for N = 4, 8 and 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | N | First operand (minuend, dividend) |
| opnd_b | input | N | Second operand (subtrahend, divisor) |
| op_sel | input | 2 | Operation code, encoded as in R1 |
| is_signed | input | 1 | 1 = two's complement, 0 = plain magnitude |
| result | output | 2N | Formatted result |
| overflow | output | 1 | Result out of range for the selected mode |
| div_zero | output | 1 | Quotient requested with a zero divisor |
| res_valid | output | 1 | Result is meaningful |

## Verification
Instances at N=4, 8 and 32 receive the same operand stream. The N=4 instance is driven through every operand pair, every operation and both modes, which covers each carry, borrow and sign combination. Directed vectors target the points where the two modes disagree: wrap against negative result, carry against sign overflow, a full-width unsigned product against a signed product, the most negative value over -1, and a zero divisor. Random operands then probe the 32-bit path, where the model's 64-bit arithmetic tells a dropped product bit or a wrong truncation direction apart from the correct result.

// File: rtl/calc_pkg.sv
package calc_pkg;
  typedef enum logic [1:0] {
    CALC_ADD = 2'b00,
    CALC_SUB = 2'b01,
    CALC_MUL = 2'b10,
    CALC_DIV = 2'b11
  } calc_op_e;
endpackage

// File: rtl/calc_addsub.sv
module calc_addsub #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         do_sub,
  input  logic         sgn,
  output logic [N-1:0] sum,
  output logic         ovf
);
  logic [N:0] wide;
  logic       sgn_ovf;

  always_comb begin
    wide = do_sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    sum  = wide[N-1:0];
    if (do_sub)
      sgn_ovf = (a[N-1] != b[N-1]) && (sum[N-1] != a[N-1]);
    else
      sgn_ovf = (a[N-1] == b[N-1]) && (sum[N-1] != a[N-1]);
    ovf = sgn ? sgn_ovf : wide[N];
  end

  always_comb begin
    if (!$isunknown({a, b, do_sub, sgn})) begin
      // R2
      uadd_wrap_chk: assert (sgn || do_sub || ovf || (sum >= a));
      // R3
      sadd_pos_chk: assert (!sgn || do_sub || a[N-1] || b[N-1] || ovf || !sum[N-1]);
    end
  end
endmodule

// File: rtl/calc_mul.sv
module calc_mul #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  input  logic           sgn,
  output logic [2*N-1:0] prod
);
  localparam int W = 2 * N;
  logic [W-1:0] ea, eb;

  always_comb begin
    ea   = sgn ? {{N{a[N-1]}}, a} : {{N{1'b0}}, a};
    eb   = sgn ? {{N{b[N-1]}}, b} : {{N{1'b0}}, b};
    prod = ea * eb;
  end

  always_comb begin
    if (!$isunknown({a, b, sgn})) begin
      // R5
      mul_zero_chk: assert ((a != '0 && b != '0) || prod == '0);
    end
  end
endmodule

// File: rtl/calc_div.sv
module calc_div #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sgn,
  output logic [N-1:0] quot,
  output logic         dz,
  output logic         ovf
);
  localparam logic [N-1:0] ONE_N = {{(N-1){1'b0}}, 1'b1};
  localparam logic [N-1:0] MIN_N = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] mag_a, mag_b, safe_b, q_mag;
  logic         neg;

  always_comb begin
    dz     = (b == '0);
    mag_a  = (sgn && a[N-1]) ? (~a + ONE_N) : a;
    mag_b  = (sgn && b[N-1]) ? (~b + ONE_N) : b;
    safe_b = dz ? ONE_N : mag_b;
    q_mag  = mag_a / safe_b;
    neg    = sgn && (a[N-1] ^ b[N-1]);
    quot   = neg ? (~q_mag + ONE_N) : q_mag;
    ovf    = sgn && (a == MIN_N) && (b == '1);
  end

  logic [2*N-1:0] back;
  always_comb begin
    back = {{N{1'b0}}, quot} * {{N{1'b0}}, b};
    if (!$isunknown({a, b, sgn})) begin
      // R6
      udiv_bound_chk: assert (sgn || dz || (back <= {{N{1'b0}}, a}));
    end
  end
endmodule

// File: rtl/calc_unit.sv
module calc_unit
  import calc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]   opnd_a,
  input  logic [N-1:0]   opnd_b,
  input  logic [1:0]     op_sel,
  input  logic           is_signed,
  output logic [2*N-1:0] result,
  output logic           overflow,
  output logic           div_zero,
  output logic           res_valid
);
  calc_op_e       op_e;
  logic [N-1:0]   as_val, dv_val;
  logic           as_ovf, dv_ovf, dv_zero;
  logic [2*N-1:0] mul_val;

  assign op_e = calc_op_e'(op_sel);

  calc_addsub #(.N(N)) u_addsub (
    .a(opnd_a), .b(opnd_b), .do_sub(op_sel[0]), .sgn(is_signed),
    .sum(as_val), .ovf(as_ovf)
  );

  calc_mul #(.N(N)) u_mul (
    .a(opnd_a), .b(opnd_b), .sgn(is_signed), .prod(mul_val)
  );

  calc_div #(.N(N)) u_div (
    .a(opnd_a), .b(opnd_b), .sgn(is_signed),
    .quot(dv_val), .dz(dv_zero), .ovf(dv_ovf)
  );

  function automatic logic [2*N-1:0] widen(input logic [N-1:0] v, input logic s);
    return {{N{s & v[N-1]}}, v};
  endfunction

  always_comb begin
    result    = '0;
    overflow  = 1'b0;
    div_zero  = 1'b0;
    res_valid = 1'b1;
    unique case (op_e)
      CALC_ADD, CALC_SUB: begin
        result   = widen(as_val, is_signed);
        overflow = as_ovf;
      end
      CALC_MUL: result = mul_val;
      CALC_DIV: begin
        if (dv_zero) begin
          div_zero  = 1'b1;
          res_valid = 1'b0;
        end else begin
          result   = widen(dv_val, is_signed);
          overflow = dv_ovf;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_sel, is_signed})) begin
      // R8
      dz_result_chk: assert (res_valid || (result == '0 && !overflow && div_zero));
      // R5
      mul_no_ovf_chk: assert (op_sel != 2'b10 || !overflow);
      // R9
      upper_fill_chk: assert (op_sel == 2'b10 ||
                              result[2*N-1:N] == {N{is_signed & result[N-1]}});
    end
  end
endmodule

// File: tb/calc_unit_bench.sv
module calc_unit_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] a_in = '0, b_in = '0;
  logic [1:0]  op_in = 2'b00;
  logic        sg_in = 1'b0;

  logic [15:0] r8;  logic o8, z8, v8;
  logic [7:0]  r4;  logic o4, z4, v4;
  logic [63:0] r32; logic o32, z32, v32;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  calc_unit #(.N(8)) u_calc_unit (
    .opnd_a(a_in[7:0]), .opnd_b(b_in[7:0]), .op_sel(op_in), .is_signed(sg_in),
    .result(r8), .overflow(o8), .div_zero(z8), .res_valid(v8));
  calc_unit #(.N(4)) u_calc_unit_n4 (
    .opnd_a(a_in[3:0]), .opnd_b(b_in[3:0]), .op_sel(op_in), .is_signed(sg_in),
    .result(r4), .overflow(o4), .div_zero(z4), .res_valid(v4));
  calc_unit #(.N(32)) u_calc_unit_n32 (
    .opnd_a(a_in), .opnd_b(b_in), .op_sel(op_in), .is_signed(sg_in),
    .result(r32), .overflow(o32), .div_zero(z32), .res_valid(v32));

  // Returns {result[63:0], overflow, div_zero, valid}
  function automatic logic [66:0] model(int w, logic [31:0] a, logic [31:0] b,
                                        logic [1:0] op, bit sg);
    logic [63:0] m, m2, lo, full;
    longint sa, sb, r, hi_lim, lo_lim;
    bit ov, dz;
    ov = 0; dz = 0; r = 0;
    m  = (64'd1 << w) - 64'd1;
    m2 = (w == 32) ? '1 : ((64'd1 << (2 * w)) - 64'd1);
    sa = longint'({32'b0, a} & m);
    sb = longint'({32'b0, b} & m);
    if (sg && sa[w-1]) sa = sa - (longint'(1) << w);
    if (sg && sb[w-1]) sb = sb - (longint'(1) << w);
    hi_lim = sg ? ((longint'(1) << (w - 1)) - 1) : longint'(m);
    lo_lim = sg ? -(longint'(1) << (w - 1)) : 0;
    case (op)
      2'b00: begin r = sa + sb; ov = (r > hi_lim) || (r < lo_lim); end
      2'b01: begin r = sa - sb; ov = (r > hi_lim) || (r < lo_lim); end
      2'b10: r = sa * sb;
      default: begin
        if (sb == 0) dz = 1;
        else if (sg && sa == lo_lim && sb == -1) begin ov = 1; r = sa; end
        else r = sa / sb;
      end
    endcase
    if (op == 2'b10) full = 64'(r) & m2;
    else begin
      lo = 64'(r) & m;
      full = (sg && lo[w-1]) ? (lo | (m2 & ~m)) : lo;
    end
    if (dz) full = '0;
    return {full, ov, dz, ~dz};
  endfunction

  function automatic string tag(int w, logic [1:0] op, bit sg, logic [31:0] b, bit ov);
    string t;
    case (op)
      2'b00: t = sg ? "R1 R3 R9" : "R1 R2";
      2'b01: t = sg ? "R4 R9" : "R2";
      2'b10: t = "R5";
      default: t = ((b & ((64'd1 << w) - 1)) == 0) ? "R8" : (ov ? "R7" : "R6 R9");
    endcase
    if (w != 8) t = {t, " R10"};
    return t;
  endfunction

  task automatic cmp(int w, logic [66:0] act);
    logic [66:0] exp;
    exp = model(w, a_in, b_in, op_in, sg_in);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s N=%0d op=%b sg=%0d a=%h b=%h: actual res=%h o/z/v=%b expected res=%h o/z/v=%b",
               tag(w, op_in, sg_in, b_in, exp[2]), w, op_in, sg_in, a_in, b_in,
               act[66:3], act[2:0], exp[66:3], exp[2:0]);
    end
  endtask

  task automatic run(logic [31:0] a, logic [31:0] b, logic [1:0] op, bit sg);
    @(posedge clk);
    a_in = a; b_in = b; op_in = op; sg_in = sg;
    @(negedge clk);
    cmp(8,  {48'b0, r8, o8, z8, v8});
    cmp(4,  {56'b0, r4, o4, z4, v4});
    cmp(32, {r32, o32, z32, v32});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // Idle state: zero operands, sum, valid high (R8)
    run(32'd0, 32'd0, 2'b00, 0);
    // R2 unsigned wrap: 250 + 20 -> 14, overflow
    run(32'd250, 32'd20, 2'b00, 0);
    run(32'd5, 32'd10, 2'b01, 0);
    // R3 signed sum overflow and its absence
    run(32'd100, 32'd50, 2'b00, 1);
    run(32'hFFFFFF9C, 32'hFFFFFFCE, 2'b00, 1);
    run(32'h7FFFFFFF, 32'd1, 2'b00, 1);
    // R4 signed difference
    run(32'd5, 32'd10, 2'b01, 1);
    run(32'd127, 32'hFFFFFFFF, 2'b01, 1);
    run(32'h80000000, 32'd1, 2'b01, 1);
    // R5 full products
    run(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b10, 0);
    run(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b10, 1);
    run(32'hFFFFFF80, 32'hFFFFFF80, 2'b10, 1);
    run(32'h80000000, 32'h80000000, 2'b10, 1);
    // R6 truncation toward zero
    run(32'hFFFFFFF9, 32'd2, 2'b11, 1);
    run(32'd7, 32'hFFFFFFFE, 2'b11, 1);
    run(32'd200, 32'd7, 2'b11, 0);
    // R7 most negative over -1
    run(32'h80000000, 32'hFFFFFFFF, 2'b11, 1);
    run(32'hFFFFFF80, 32'hFFFFFFFF, 2'b11, 1);
    // R8 zero divisor in both modes
    run(32'd123, 32'd0, 2'b11, 0);
    run(32'hFFFFFF80, 32'd0, 2'b11, 1);
    // Exhaustive 4-bit sweep (R10 and every flag rule at small width)
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 4; o++)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++)
            run(32'(x) | 32'hFFFFFF00, 32'(y), 2'(o), bit'(s));
    // Random wide operands
    for (int i = 0; i < 600; i++)
      run($urandom, (i % 7 == 0) ? 32'd0 : $urandom, 2'(i % 4), bit'((i / 4) % 2));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule